// File: doc/BRIEF.md
# Byte-Lane Static RAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 262,144 words by 16 bits with a shared tri-state data bus. The host hands over one request at a time: a read or a write, an 18-bit word address, 16 bits of write data and two active-high lane enables. Enable bit 0 selects the lower lane, data bits 7..0. Enable bit 1 selects the upper lane, data bits 15..8. The controller turns each request into one memory access. It drives the chip enable, output enable, write enable and the two active-low lane strobes. It holds that combination for a fixed number of clocks that covers the memory's access time, then answers the host with a one-cycle response.

The request side is a valid/ready port. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host must hold every request field steady. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the host must take `rsp_rdata` in that cycle.

The controller drives the data bus only while write enable is low. When a read follows a write, it adds one extra released cycle so that the memory cannot start driving the bus while the host side still holds it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, chip enable, output enable, write enable and both lane strobes are high (inactive), `rsp_valid` is low and `req_ready` is high.
- R2: Outside an access, chip enable is high and output and write enable are high, including the cycle in which `rsp_valid` is high.
- R3: During a read, chip enable and output enable are low and write enable is high. The upper strobe is low exactly when enable bit 1 is set, and the lower strobe is low exactly when enable bit 0 is set. Chip enable is never low while both strobes are high.
- R4: A read response carries the bus value captured in the final strobe cycle on the enabled lanes, and zero on disabled lanes.
- R5: During a write, chip enable and write enable are low and output enable stays high. The bus carries the request's write data, and only the enabled lanes' strobes are low, so only those lanes change in memory.
- R6: Each access keeps its strobes low for exactly WAIT_CYCLES clocks, equal to ceil(ACCESS_NS / CLK_NS) and 25 by default. Address, lane strobes and write enable are steady throughout the access.
- R7: `rsp_valid` is high for the cycle after the last strobe cycle. For a read that does not follow a write, and for any write, this is WAIT_CYCLES clock edges after the accepting edge.
- R8: A request with both enable bits clear is answered in the cycle right after acceptance and produces no chip-enable activity. A write of this kind leaves memory unchanged.
- R9: A read whose previous memory access was a write waits one extra cycle, with latency WAIT_CYCLES + 1. There are at least two cycles with chip enable high between the end of the write and the start of the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_be | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, enabled lanes only |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq | inout | 16 | Shared tri-state data bus |

## Verification
The hardest case to reach from the ports is a read accepted right after a write has finished. Only this case passes through the turnaround cycle, and it is easily hidden when the host leaves idle gaps. The stimulus therefore issues each request at the first negative edge after the previous response. It draws reads and writes at random over a small address pool, so write-then-read pairs to the same word occur often. Directed cases cover the extreme addresses, single-lane writes merging into one word, and empty-lane requests placed between a write and a read.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_READ  = 2'd2,
    ST_WRITE = 2'd3
  } ctrl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/sram_hold_timer.sv
module sram_hold_timer #(
  parameter int HOLD = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic active,
  output logic last
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] TOP = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= TOP;
    end else if (active && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = active && (cnt == '0);

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= TOP);

  assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge #(
  parameter int LANES = 2,
  parameter int LW    = 8
) (
  input  logic [LANES-1:0]    sel,
  input  logic                active,
  input  logic [LANES*LW-1:0] bus,
  output logic [LANES*LW-1:0] masked,
  output logic [LANES-1:0]    strobe_n
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign masked[i*LW +: LW] = sel[i] ? bus[i*LW +: LW] : '0;
    assign strobe_n[i]        = !(active && sel[i]);
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW          = 18,
  parameter int DW          = 16,
  parameter int CLK_NS      = 4,
  parameter int ACCESS_NS   = 100,
  parameter int WAIT_CYCLES = ceil_div(ACCESS_NS, CLK_NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_be,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  inout  wire  [DW-1:0] mem_dq
);
  localparam int LANES = 2;
  localparam int LW    = DW / LANES;
  localparam int RW    = $clog2(WAIT_CYCLES + 2) + 1;

  ctrl_state_e      state, state_d;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic             last_wr;
  logic             accept;
  logic             hold_last;
  logic             hold_load;
  logic             access;
  logic             dq_oe;
  logic [DW-1:0]    rd_masked;
  logic [LANES-1:0] lane_n;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE: begin
        if (accept && req_be != '0) begin
          if (req_we)       state_d = ST_WRITE;
          else if (last_wr) state_d = ST_TURN;
          else              state_d = ST_READ;
        end
      end
      ST_TURN:  state_d = ST_READ;
      ST_READ:  if (hold_last) state_d = ST_IDLE;
      ST_WRITE: if (hold_last) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign access    = (state == ST_READ) || (state == ST_WRITE);
  assign hold_load = ((state_d == ST_READ) || (state_d == ST_WRITE)) && !access;

  sram_hold_timer #(.HOLD(WAIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold_load),
    .active (access),
    .last   (hold_last)
  );

  sram_lane_merge #(.LANES(LANES), .LW(LW)) u_lanes (
    .sel      (be_q),
    .active   (access),
    .bus      (mem_dq),
    .masked   (rd_masked),
    .strobe_n (lane_n)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      last_wr   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state     <= state_d;
      rsp_valid <= 1'b0;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        if (req_be == '0) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= '0;
        end
      end
      if (state == ST_READ && hold_last) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_masked;
        last_wr   <= 1'b0;
      end
      if (state == ST_WRITE && hold_last) begin
        rsp_valid <= 1'b1;
        last_wr   <= 1'b1;
      end
    end
  end

  assign dq_oe    = (state == ST_WRITE);
  assign mem_dq   = dq_oe ? wdata_q : 'z;
  assign mem_addr = addr_q;
  assign mem_ce_n = !access;
  assign mem_oe_n = (state != ST_READ);
  assign mem_we_n = (state != ST_WRITE);
  assign mem_ub_n = lane_n[1];
  assign mem_lb_n = lane_n[0];

  // checker state: length of the current chip-enable low run
  logic [RW-1:0] chk_run;
  always_ff @(posedge clk) begin
    if (!rst_n)        chk_run <= '0;
    else if (!mem_ce_n) chk_run <= chk_run + 1'b1;
    else               chk_run <= '0;
  end

  assert_lane_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (!mem_ub_n || !mem_lb_n));

  assert_read_combo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  assert_write_combo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));

  assert_drive_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !mem_we_n);

  assert_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |->
      ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n) && $stable(mem_we_n)));

  assert_hold_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (chk_run == RW'(WAIT_CYCLES)));

  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n && mem_we_n));

  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  assert_turnaround_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> ($past(mem_we_n) && $past(mem_we_n, 2)));

  assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_be == '0) |=> (mem_ce_n && rsp_valid));

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int W = (100 + 4 - 1) / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  wire  [15:0] mem_dq;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq(mem_dq)
  );

  // behavioural memory and scoreboard
  logic [15:0] model_mem [logic [17:0]];
  logic [15:0] exp_mem   [logic [17:0]];
  logic [15:0] model_word = '0;

  function automatic logic [15:0] init_val(input logic [17:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] model_peek(input logic [17:0] a);
    return model_mem.exists(a) ? model_mem[a] : init_val(a);
  endfunction

  function automatic logic [15:0] exp_peek(input logic [17:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : init_val(a);
  endfunction

  function automatic logic [15:0] lane_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  always @(negedge clk) model_word <= model_peek(mem_addr);

  assign mem_dq[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? model_word[7:0]  : 8'bz;
  assign mem_dq[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? model_word[15:8] : 8'bz;

  always @(posedge clk) begin
    if (!mem_ce_n && !mem_we_n) begin
      logic [15:0] w;
      w = model_peek(mem_addr);
      if (!mem_lb_n) w[7:0]  = mem_dq[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq[15:8];
      model_mem[mem_addr] = w;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin monitor
  logic        cur_we = 1'b0;
  logic [1:0]  cur_be = '0;
  logic [17:0] cur_addr = '0;
  logic [15:0] cur_wdata = '0;
  int  ce_falls = 0;
  int  low_run = 0;
  int  high_run = 0;
  bit  prev_ce = 1'b1;
  bit  prev_was_wr = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && prev_ce) begin
        ce_falls++;
        check(mem_ub_n == !cur_be[1] && mem_lb_n == !cur_be[0], "R3 lane strobes",
              {mem_ub_n, mem_lb_n}, {!cur_be[1], !cur_be[0]});
        check(mem_addr == cur_addr, "R6 address", mem_addr, cur_addr);
        if (cur_we) begin
          check(!mem_we_n && mem_oe_n, "R5 write combo", {mem_we_n, mem_oe_n}, 2'b01);
          check((mem_dq & lane_mask(cur_be)) == (cur_wdata & lane_mask(cur_be)),
                "R5 bus data", mem_dq, cur_wdata);
        end else begin
          check(!mem_oe_n && mem_we_n, "R3 read combo", {mem_we_n, mem_oe_n}, 2'b10);
          if (prev_was_wr)
            check(high_run >= 2, "R9 gap after write", high_run, 2);
        end
      end
      if (mem_ce_n && !prev_ce) begin
        check(low_run == W, "R6 hold length", low_run, W);
        prev_was_wr = !mem_we_n ? 1'b1 : cur_we;
      end
      if (!mem_ce_n) begin low_run++; high_run = 0; end
      else begin high_run++; low_run = 0; end
      prev_ce = mem_ce_n;
    end
  end

  bit last_host_wr = 1'b0;

  task automatic run_req(input bit wr, input logic [17:0] a, input logic [1:0] be, input logic [15:0] wd);
    int lat;
    int exp_lat;
    int falls0;
    bit turn;
    logic [15:0] expd;
    turn = !wr && be != 2'b00 && last_host_wr;
    expd = exp_peek(a) & lane_mask(be);
    @(negedge clk);
    req_valid = 1'b1; req_we = wr; req_addr = a; req_be = be; req_wdata = wd;
    cur_we = wr; cur_be = be; cur_addr = a; cur_wdata = wd;
    while (!req_ready) @(negedge clk);
    falls0 = ce_falls;
    @(posedge clk); #1;
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 1000) begin @(posedge clk); #1; lat++; end
    exp_lat = (be == 2'b00) ? 0 : (turn ? W + 1 : W);
    if (be == 2'b00) begin
      check(lat == exp_lat, "R8 empty latency", lat, exp_lat);
      check(ce_falls == falls0, "R8 no chip enable", ce_falls, falls0);
    end else if (turn) begin
      check(lat == exp_lat, "R9 turnaround latency", lat, exp_lat);
    end else begin
      check(lat == exp_lat, "R7 latency", lat, exp_lat);
    end
    check(mem_ce_n && mem_oe_n && mem_we_n, "R2 idle at response",
          {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
    if (!wr)
      check(rsp_rdata == expd, "R4 read data", rsp_rdata, expd);
    if (wr) begin
      exp_mem[a] = (exp_peek(a) & ~lane_mask(be)) | (wd & lane_mask(be));
    end
    if (be != 2'b00) last_host_wr = wr;
  endtask

  function automatic logic [17:0] pool_addr(input int i);
    return 18'(i * 18'h4111);
  endfunction

  initial begin
    void'($urandom(32'd7351));
    repeat (3) @(posedge clk);
    #1;
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n, "R1 strobes in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1f);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
    check(mem_ce_n, "R2 idle chip enable", mem_ce_n, 1);

    // directed corners
    run_req(1'b1, 18'h00000, 2'b11, 16'h1234);
    run_req(1'b0, 18'h00000, 2'b11, 16'h0);       // R9 read right after write
    run_req(1'b0, 18'h00000, 2'b11, 16'h0);       // R7 read after read
    run_req(1'b1, 18'h3FFFF, 2'b01, 16'hBEEF);    // lower only
    run_req(1'b1, 18'h3FFFF, 2'b10, 16'hCAFE);    // upper only
    run_req(1'b0, 18'h3FFFF, 2'b11, 16'h0);       // expect CAEF
    run_req(1'b0, 18'h3FFFF, 2'b10, 16'h0);       // R4 upper lane only
    run_req(1'b0, 18'h3FFFF, 2'b01, 16'h0);       // R4 lower lane only
    run_req(1'b1, 18'h00000, 2'b00, 16'hFFFF);    // R8 empty write
    run_req(1'b0, 18'h00000, 2'b00, 16'h0);       // R8 empty read
    run_req(1'b0, 18'h00000, 2'b11, 16'h0);       // still 1234
    run_req(1'b1, 18'h00123, 2'b11, 16'h5555);
    run_req(1'b1, 18'h00123, 2'b00, 16'hAAAA);    // empty between write and read
    run_req(1'b0, 18'h00123, 2'b11, 16'h0);       // R9 still turns around

    // random mix over a small pool
    for (int n = 0; n < 220; n++) begin
      bit wr;
      logic [1:0] be;
      wr = 1'($urandom % 2);
      be = 2'($urandom % 4);
      run_req(wr, pool_addr(int'($urandom % 16)), be, 16'($urandom));
    end

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule